// File: doc/BRIEF.md
# Auto-Retry Transmit Controller

This block sequences one automatic transmit transaction for a low-rate 2.4 GHz packet radio. When a start request arrives in the idle state, it captures its settings. It then asks an external backoff unit for channel access, fires a one-cycle transmit trigger toward the modem and waits for the modem to report that the frame has left. If the outgoing frame asked for an acknowledgement, the block opens a programmable acknowledgement window. It retries the whole access-and-send sequence until an acknowledgement arrives or the frame retry budget is used up.

The block reports a busy flag and a 3-bit result code, and pulses a maskable completion interrupt. A channel-access setting of all ones is a special case. It skips the backoff handshake, starts transmission at once and allows exactly one attempt, whatever the frame retry limit is. The result code separates a plain acknowledgement from one that carries the frame-pending flag. The modem, CRC, random backoff timing and frame storage are outside this block.

Top module: `artx_ctrl`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it rises, `busy_o`, `irq_o`, `csma_req_o` and `tx_start_o` are 0 and `result_o` is 7 (INVALID). An assertion of reset in the middle of a transaction aborts it.
- R2: `start_i` is accepted only while `busy_o` is 0. On the next cycle `busy_o` is 1 and `result_o` is 7, and `result_o` stays 7 for as long as `busy_o` is 1. `start_i` and changes to the settings inputs while busy have no effect, because the settings are captured at acceptance.
- R3: When the captured channel-access setting is not 7, `csma_req_o` is held high from the cycle after acceptance (and from the cycle after each expired acknowledgement window) until `csma_done_i` or `csma_fail_i` is seen. A grant makes `tx_start_o` high on the next cycle.
- R4: `csma_fail_i` during a channel-access request ends the transaction with `result_o` = 3 (CHANNEL_FAIL). When both inputs are high together, the failure wins.
- R5: When the captured channel-access setting is 7, `tx_start_o` rises on the cycle after acceptance. `csma_req_o` never rises, and exactly one transmit attempt is made.
- R6: `tx_start_o` is a one-cycle pulse, one per attempt. After `tx_done_i`, a frame without an acknowledgement request ends with `result_o` = 0 (SUCCESS).
- R7: An `ack_valid_i` inside the acknowledgement window ends the transaction with `result_o` = 1 (SUCCESS_DATA_PENDING) if `ack_pend_i` is 1 and with 0 otherwise.
- R8: The acknowledgement window is the T cycles after the cycle in which `tx_done_i` is taken, where T is the captured timeout (0 counts as 1). `ack_valid_i`, `tx_done_i`, `csma_done_i` and `csma_fail_i` have no effect outside the states that wait for them, and that includes idle.
- R9: An expired window counts one failed attempt. While the failed attempts are at most the frame retry limit, channel access restarts on the next cycle. After limit+1 failed attempts the transaction ends with `result_o` = 5 (NO_ACK).
- R10: On the first idle cycle after a transaction, `irq_o` is a one-cycle pulse when `irq_en_i` was high on the completing cycle. Otherwise it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one transmit transaction |
| csma_retries_i | input | CSMA_W | Channel-access retry setting; all ones selects bypass |
| frame_retries_i | input | RETRY_W | Frame retry limit |
| ack_req_i | input | 1 | Outgoing frame requests an acknowledgement |
| ack_timeout_i | input | TMO_W | Acknowledgement window length in cycles |
| irq_en_i | input | 1 | Completion interrupt enable |
| csma_done_i | input | 1 | Backoff unit reports the channel clear |
| csma_fail_i | input | 1 | Backoff unit reports access failure |
| tx_done_i | input | 1 | Modem reports the frame sent |
| ack_valid_i | input | 1 | Valid acknowledgement received |
| ack_pend_i | input | 1 | Frame-pending flag of that acknowledgement |
| csma_req_o | output | 1 | Channel-access request to the backoff unit |
| tx_start_o | output | 1 | One-cycle transmit trigger |
| busy_o | output | 1 | Transaction in progress |
| result_o | output | 3 | Result code: 0, 1, 3, 5 or 7 |
| irq_o | output | 1 | Completion interrupt pulse |

## Verification
The assertions check on every cycle the local handshake rules: acceptance only from idle, INVALID held while busy, a grant becoming a transmit pulse, a failure ending with code 3, single-cycle transmit and interrupt pulses, and idle ignoring stray acknowledgements. Some behaviours are visible only across a whole transaction. These are the exact length of the acknowledgement window, the number of attempts against the retry limit, the bypass giving one attempt with no channel access, and the choice between codes 0, 1 and 5. The bench's scenarios check these against a reference model. Those scenarios also change the settings and start inputs while busy.

// File: rtl/artx_pkg.sv
`timescale 1ns/1ps
package artx_pkg;

  typedef enum logic [2:0] {
    RES_SUCCESS      = 3'd0,
    RES_SUCCESS_PEND = 3'd1,
    RES_CHAN_FAIL    = 3'd3,
    RES_NO_ACK       = 3'd5,
    RES_INVALID      = 3'd7
  } artx_res_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CSMA,
    ST_TX_GO,
    ST_TX_WAIT,
    ST_ACK_WAIT
  } artx_state_e;

  typedef struct packed {
    logic bypass;
    logic ack_req;
  } artx_flags_t;

endpackage

// File: rtl/artx_retry_cnt.sv
`timescale 1ns/1ps
module artx_retry_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] limit_i,
  output logic         exhausted_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + W'(1);
  end

  // one more failure would exceed the limit
  assign exhausted_o = (cnt_q >= limit_i);
endmodule

// File: rtl/artx_ack_timer.sv
`timescale 1ns/1ps
module artx_ack_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  input  logic         run_i,
  output logic         expire_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= (len_i == '0) ? ONE : len_i;
    else if (run_i && cnt_q > ONE)   cnt_q <= cnt_q - ONE;
  end

  assign expire_o = run_i && (cnt_q <= ONE);
endmodule

// File: rtl/artx_ctrl.sv
`timescale 1ns/1ps
module artx_ctrl
  import artx_pkg::*;
#(
  parameter int CSMA_W  = 3,
  parameter int RETRY_W = 4,
  parameter int TMO_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [CSMA_W-1:0]  csma_retries_i,
  input  logic [RETRY_W-1:0] frame_retries_i,
  input  logic               ack_req_i,
  input  logic [TMO_W-1:0]   ack_timeout_i,
  input  logic               irq_en_i,
  input  logic               csma_done_i,
  input  logic               csma_fail_i,
  input  logic               tx_done_i,
  input  logic               ack_valid_i,
  input  logic               ack_pend_i,
  output logic               csma_req_o,
  output logic               tx_start_o,
  output logic               busy_o,
  output logic [2:0]         result_o,
  output logic               irq_o
);
  localparam logic [CSMA_W-1:0] CSMA_BYPASS = '1;

  artx_state_e        state_q, state_d;
  artx_res_e          res_q, res_d, fin_code;
  artx_flags_t        flags_q;
  logic [RETRY_W-1:0] limit_q;
  logic [TMO_W-1:0]   tmo_q;
  logic               irq_q;
  logic               start_ok, fin;
  logic               tmr_load, tmr_expire, rty_inc, rty_exhausted;

  assign start_ok = (state_q == ST_IDLE) && start_i;

  artx_retry_cnt #(.W(RETRY_W)) u_rty (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (start_ok),
    .inc_i       (rty_inc),
    .limit_i     (limit_q),
    .exhausted_o (rty_exhausted)
  );

  artx_ack_timer #(.W(TMO_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .len_i    (tmo_q),
    .run_i    (state_q == ST_ACK_WAIT),
    .expire_o (tmr_expire)
  );

  always_comb begin
    state_d  = state_q;
    fin      = 1'b0;
    fin_code = RES_INVALID;
    tmr_load = 1'b0;
    rty_inc  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) state_d = (csma_retries_i == CSMA_BYPASS) ? ST_TX_GO : ST_CSMA;
      end
      ST_CSMA: begin
        if (csma_fail_i) begin
          fin      = 1'b1;
          fin_code = RES_CHAN_FAIL;
        end else if (csma_done_i) begin
          state_d = ST_TX_GO;
        end
      end
      ST_TX_GO: state_d = ST_TX_WAIT;
      ST_TX_WAIT: begin
        if (tx_done_i) begin
          if (flags_q.ack_req) begin
            state_d  = ST_ACK_WAIT;
            tmr_load = 1'b1;
          end else begin
            fin      = 1'b1;
            fin_code = RES_SUCCESS;
          end
        end
      end
      ST_ACK_WAIT: begin
        if (ack_valid_i) begin
          fin      = 1'b1;
          fin_code = ack_pend_i ? RES_SUCCESS_PEND : RES_SUCCESS;
        end else if (tmr_expire) begin
          rty_inc = 1'b1;
          if (flags_q.bypass || rty_exhausted) begin
            fin      = 1'b1;
            fin_code = RES_NO_ACK;
          end else begin
            state_d = ST_CSMA;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (fin) state_d = ST_IDLE;
  end

  always_comb begin
    res_d = res_q;
    if (start_ok) res_d = RES_INVALID;
    else if (fin) res_d = fin_code;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      res_q   <= RES_INVALID;
      irq_q   <= 1'b0;
      flags_q <= '0;
      limit_q <= '0;
      tmo_q   <= '0;
    end else begin
      state_q <= state_d;
      res_q   <= res_d;
      irq_q   <= fin && irq_en_i;
      if (start_ok) begin
        flags_q.bypass  <= (csma_retries_i == CSMA_BYPASS);
        flags_q.ack_req <= ack_req_i;
        limit_q         <= frame_retries_i;
        tmo_q           <= ack_timeout_i;
      end
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign csma_req_o = (state_q == ST_CSMA);
  assign tx_start_o = (state_q == ST_TX_GO);
  assign result_o   = res_q;
  assign irq_o      = irq_q;
endmodule

// File: rtl/artx_ctrl_chk.sv
`timescale 1ns/1ps
module artx_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       csma_done_i,
  input logic       csma_fail_i,
  input logic       ack_valid_i,
  input logic       csma_req_o,
  input logic       tx_start_o,
  input logic       busy_o,
  input logic [2:0] result_o,
  input logic       irq_o
);
  a_r1_reset_state: assert property (@(posedge clk_i)
    !rst_ni |=> (!busy_o && !irq_o && !csma_req_o && !tx_start_o && result_o == 3'd7));

  a_r2_start_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && result_o == 3'd7));

  a_r2_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> !busy_o);

  a_r2_busy_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> result_o == 3'd7);

  a_r3_grant_to_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csma_req_o && csma_done_i && !csma_fail_i) |=> (tx_start_o && !csma_req_o));

  a_r3_req_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csma_req_o || tx_start_o) |-> (busy_o && !(csma_req_o && tx_start_o)));

  a_r4_chan_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csma_req_o && csma_fail_i) |=> (!busy_o && result_o == 3'd3));

  a_r6_tx_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |=> !tx_start_o);

  a_r8_idle_ack_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i && ack_valid_i) |=> $stable(result_o));

  a_r10_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  a_r10_irq_on_finish: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (!busy_o && $past(busy_o)));
endmodule

bind artx_ctrl artx_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .csma_done_i (csma_done_i),
  .csma_fail_i (csma_fail_i),
  .ack_valid_i (ack_valid_i),
  .csma_req_o  (csma_req_o),
  .tx_start_o  (tx_start_o),
  .busy_o      (busy_o),
  .result_o    (result_o),
  .irq_o       (irq_o)
);

// File: tb/artx_ctrl_tb_top.sv
`timescale 1ns/1ps
module artx_ctrl_tb_top;
  localparam int CSMA_W  = 3;
  localparam int RETRY_W = 4;
  localparam int TMO_W   = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [CSMA_W-1:0]  csma_retries_i = '0;
  logic [RETRY_W-1:0] frame_retries_i = '0;
  logic ack_req_i = 1'b0;
  logic [TMO_W-1:0] ack_timeout_i = '0;
  logic irq_en_i = 1'b0;
  logic csma_done_i = 1'b0, csma_fail_i = 1'b0, tx_done_i = 1'b0;
  logic ack_valid_i = 1'b0, ack_pend_i = 1'b0;
  logic csma_req_o, tx_start_o, busy_o, irq_o;
  logic [2:0] result_o;

  always #2.5 clk_i = ~clk_i;

  artx_ctrl #(.CSMA_W(CSMA_W), .RETRY_W(RETRY_W), .TMO_W(TMO_W)) dut_i (
    .clk_i, .rst_ni, .start_i, .csma_retries_i, .frame_retries_i, .ack_req_i,
    .ack_timeout_i, .irq_en_i, .csma_done_i, .csma_fail_i, .tx_done_i,
    .ack_valid_i, .ack_pend_i, .csma_req_o, .tx_start_o, .busy_o, .result_o, .irq_o
  );

  int n_checks = 0;
  int n_errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference model: result, attempts, channel-access rounds
  function automatic void model(input int cs, input int fr, input bit ar, input int tmo,
                                input int aa, input int ak, input bit pend, input int fround,
                                output int res, output int att, output int rounds);
    bit byp = (cs == 7);
    int maxa = byp ? 1 : fr + 1;
    res = -1; att = 0; rounds = 0;
    for (int a = 0; a < 32; a++) begin
      if (!byp) begin
        rounds++;
        if (fround == a) begin res = 3; break; end
      end
      att++;
      if (!ar) begin res = 0; break; end
      if (a == aa && ak <= tmo) begin res = pend ? 1 : 0; break; end
      if (att >= maxa) begin res = 5; break; end
    end
  endfunction

  task automatic run_txn(input int cs, input int fr, input bit ar, input int tmo,
                         input int aa, input int ak, input bit pend, input int fround,
                         input int cdel, input bit ien, input bit noise);
    int exp_res, exp_att, exp_rounds;
    int att_seen = 0, rounds_seen = 0, csma_cyc = 0, since = 0;
    bit done_pend = 0, track = 0, armed = 0;
    string tag;
    model(cs, fr, ar, tmo, aa, ak, pend, fround, exp_res, exp_att, exp_rounds);
    tag = (exp_res == 3) ? "R4" : (exp_res == 5) ? "R9" : (!ar) ? "R6" : "R7";

    @(negedge clk_i);
    csma_retries_i  = CSMA_W'(cs);
    frame_retries_i = RETRY_W'(fr);
    ack_req_i       = ar;
    ack_timeout_i   = TMO_W'(tmo);
    irq_en_i        = ien;
    start_i         = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R2", "busy after start", int'(busy_o), 1);
    check(result_o == 3'd7, "R2", "result while busy", int'(result_o), 7);
    if (cs == 7) check(tx_start_o == 1'b1, "R5", "bypass immediate tx", int'(tx_start_o), 1);

    for (int cyc = 0; cyc < 3000; cyc++) begin
      if (cyc > 0) @(negedge clk_i);
      csma_done_i = 0; csma_fail_i = 0; tx_done_i = 0;
      ack_valid_i = 0; ack_pend_i = 0; start_i = 0;
      since++;
      if (track) begin
        if (since == tmo)
          check(busy_o && !csma_req_o && !tx_start_o, "R8", "window still open",
                int'(csma_req_o), 0);
        if (since == tmo + 1) begin
          check(csma_req_o || !busy_o, "R9", "retry or end after timeout",
                int'(busy_o), 0);
          track = 0;
        end
      end
      if (!busy_o) break;
      if (noise) begin
        start_i         = 1'($urandom_range(0, 1));
        csma_retries_i  = CSMA_W'($urandom_range(0, 7));
        frame_retries_i = RETRY_W'($urandom_range(0, 15));
        ack_req_i       = 1'($urandom_range(0, 1));
        ack_timeout_i   = TMO_W'($urandom_range(0, 9));
      end
      if (armed && since == ak) begin
        ack_valid_i = 1; ack_pend_i = pend; armed = 0;
        if (ak <= tmo) track = 0;
      end
      if (done_pend) begin
        tx_done_i = 1; done_pend = 0; since = 0;
        track = ar;
        armed = ar && (att_seen - 1 == aa);
      end
      if (tx_start_o) begin att_seen++; done_pend = 1; end
      if (csma_req_o) begin
        csma_cyc++;
        if (csma_cyc == 1) rounds_seen++;
        if (csma_cyc >= cdel) begin
          if (rounds_seen - 1 == fround) csma_fail_i = 1;
          else csma_done_i = 1;
          csma_cyc = 0;
        end
      end
    end

    check(result_o == 3'(exp_res), tag, "final result", int'(result_o), exp_res);
    check(att_seen == exp_att, (cs == 7) ? "R5" : "R9", "attempt count", att_seen, exp_att);
    check(rounds_seen == exp_rounds, "R3", "access rounds", rounds_seen, exp_rounds);
    check(irq_o == ien, "R10", "irq on finish", int'(irq_o), int'(ien));
    // stray completions while idle
    ack_valid_i = 1; ack_pend_i = 1; tx_done_i = 1; csma_done_i = 1; csma_fail_i = 1;
    @(negedge clk_i);
    ack_valid_i = 0; ack_pend_i = 0; tx_done_i = 0; csma_done_i = 0; csma_fail_i = 0;
    check(irq_o == 1'b0, "R10", "irq single cycle", int'(irq_o), 0);
    check(!busy_o, "R8", "idle stays idle", int'(busy_o), 0);
    check(result_o == 3'(exp_res), "R8", "idle ignores stray ack", int'(result_o), exp_res);
  endtask

  initial begin
    #(5.0 * 150000);
    n_errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    check(!busy_o && !irq_o && !csma_req_o && !tx_start_o, "R1", "reset outputs", int'(busy_o), 0);
    check(result_o == 3'd7, "R1", "reset result", int'(result_o), 7);
    rst_ni = 1'b1;

    // directed       cs fr ar tmo aa ak pend fr cdel irq noise
    run_txn(3, 2, 0, 3, -1, 0, 0, -1, 2, 1, 0);   // R6 no ack requested
    run_txn(3, 2, 1, 4, 0, 1, 0, -1, 1, 1, 0);    // R7 clean ack
    run_txn(2, 2, 1, 4, 0, 4, 1, -1, 3, 1, 0);    // R7 pending ack at window end
    run_txn(1, 2, 1, 3, -1, 0, 0, -1, 1, 1, 0);   // R9 three attempts
    run_txn(7, 5, 1, 2, -1, 0, 0, -1, 1, 1, 0);   // R5 bypass one attempt
    run_txn(7, 5, 0, 2, -1, 0, 0, -1, 1, 1, 0);   // R5 bypass no ack
    run_txn(4, 1, 1, 2, -1, 0, 0, 0, 2, 1, 0);    // R4 first round fails
    run_txn(4, 3, 1, 2, -1, 0, 0, 1, 1, 1, 0);    // R4 fail on retry round
    run_txn(0, 1, 1, 3, 0, 4, 0, -1, 1, 1, 0);    // R8 late ack ignored
    run_txn(0, 0, 1, 1, -1, 0, 0, -1, 1, 1, 0);   // R9 limit zero
    run_txn(5, 1, 1, 2, 1, 2, 1, -1, 2, 0, 1);    // R10 masked, R2 noise

    for (int i = 0; i < 60; i++) begin
      int tmo = $urandom_range(1, 5);
      int fround = ($urandom_range(0, 5) == 0) ? $urandom_range(0, 2) : -1;
      run_txn($urandom_range(0, 7), $urandom_range(0, 3), 1'($urandom_range(0, 3) != 0),
              tmo, $urandom_range(0, 4) - 1, $urandom_range(1, tmo + 1),
              1'($urandom_range(0, 1)), fround, $urandom_range(1, 4),
              1'($urandom_range(0, 1)), 1'b1);
    end

    // R1 reset mid transaction
    @(negedge clk_i);
    csma_retries_i = 3'd2; ack_req_i = 1; start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    @(negedge clk_i);
    check(busy_o, "R1", "busy before abort", int'(busy_o), 1);
    #1 rst_ni = 1'b0;
    #1;
    check(!busy_o && !csma_req_o, "R1", "abort to idle", int'(busy_o), 0);
    check(result_o == 3'd7, "R1", "abort result", int'(result_o), 7);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o, "R1", "idle after release", int'(busy_o), 0);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule